// File: doc/BRIEF.md
# Synthesizer Divider Configuration Registers

This block holds the divider settings of an integer-N clock synthesizer. It drives a 10-bit feedback multiplier `m_out`, a 1-bit pre-divider select `p_out` and two 3-bit post-divider codes `na_out` and `nb_out`. The settings come from one of two sources, picked by the `par_load` input. One source is a bank of parallel pins. The other is a set of three byte registers that an I2C-compatible serial slave can write and read back.

The slave runs on the system clock. It oversamples SCL and SDA through synchronizers and drives SDA in open-drain form: `sda_oe` high means the pin is pulled low. The first data byte of a write sets a register pointer, and each later byte goes into the register under that pointer, which then advances. A read returns bytes from the pointer onward. Bytes written over I2C are held in a staging set. They reach the dividers only at the STOP that ends a write, so the dividers never see half of an update.

Top module: `synth_cfg_regs`

## Requirements
- R1: A synchronous active-high `rst` clears all divider outputs, the serial registers and the pointer to zero, and releases `sda_oe`. Outputs read zero on the edge after reset.
- R2: While `par_load` is 1, the divider outputs take the values on `par_m`, `par_p`, `par_na` and `par_nb`. A change on those pins shows on the outputs at the third rising clock edge after it, and not before.
- R3: While `par_load` is 1, serial writes have no effect on the outputs. When `par_load` returns to 0, the outputs show the last values committed over I2C.
- R4: The 7-bit device address is {1101, addr_strap[1], addr_strap[0], 0}. An address byte is that address followed by the R/W bit (1 = read). A different address gets no ACK, and the transfer after it changes nothing.
- R5: After a matching address, the slave ACKs the pointer byte and every data byte of a write.
- R6: Register layout. Byte 0 is {000000, M[9:8]}, and in a write only its bits 1:0 are kept. Byte 1 is M[7:0]. Byte 2 is {P, NA[2:0], NB[2:0], 0}. P = 1 means pre-divide by 4 and P = 0 means pre-divide by 2.
- R7: The pointer advances after every byte transferred and wraps from 2 to 0. A pointer byte of 3 or more selects byte 0.
- R8: Divider outputs change only at a STOP that ends a transfer in which data bytes were written. Before that STOP they keep their previous value.
- R9: A read (address with R/W = 1) returns register bytes from the current pointer, MSB first, and advances the pointer. It continues while the master ACKs and ends at the master's NACK.
- R10: `sda_oe` changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_load | input | 1 | 1 = parallel pins drive the dividers, 0 = serial registers drive them |
| par_m | input | 10 | Parallel feedback multiplier |
| par_p | input | 1 | Parallel pre-divider select |
| par_na | input | 3 | Parallel post-divider code, output A |
| par_nb | input | 3 | Parallel post-divider code, output B |
| addr_strap | input | 2 | Device address bits 2 and 1 |
| scl | input | 1 | Serial clock line |
| sda_in | input | 1 | Serial data line as seen on the pin |
| sda_oe | output | 1 | Pull SDA low when 1 |
| m_out | output | 10 | Feedback multiplier to the PLL |
| p_out | output | 1 | Pre-divider select to the PLL |
| na_out | output | 3 | Post-divider code A |
| nb_out | output | 3 | Post-divider code B |

## Verification
A parallel pin change passes through two synchronizer flops and the output register, so it is due on the third rising edge. The bench samples on the falling edges after the second edge and after the third edge, to show that the output is not early and not late. A serial commit lands four edges after SDA rises for the STOP. The ACK or data drive appears about three edges after an SCL fall. The bench therefore holds each SCL phase for six clocks, samples SDA halfway through the high phase, and waits eight clocks after a STOP before it compares the outputs.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

    localparam int M_W     = 10;
    localparam int N_W     = 3;
    localparam int REG_CNT = 3;
    localparam int PTR_W   = 2;
    localparam int CFG_W   = M_W + 1 + 2 * N_W;

    typedef struct packed {
        logic [M_W-1:0] m;
        logic           p;
        logic [N_W-1:0] na;
        logic [N_W-1:0] nb;
    } div_cfg_t;

    typedef enum logic [2:0] {
        SL_IDLE,
        SL_RX,
        SL_ACK,
        SL_TX,
        SL_RACK
    } sl_state_t;

    typedef enum logic [1:0] {
        ROLE_ADDR,
        ROLE_PTR,
        ROLE_DATA
    } role_t;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(REG_CNT - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    function automatic logic [7:0] cfg_read_byte(input div_cfg_t c,
                                                 input logic [PTR_W-1:0] idx);
        logic [7:0] b;
        case (idx)
            2'd0:    b = {6'b0, c.m[M_W-1:8]};
            2'd1:    b = c.m[7:0];
            default: b = {c.p, c.na, c.nb, 1'b0};
        endcase
        return b;
    endfunction

    function automatic div_cfg_t cfg_write_byte(input div_cfg_t c,
                                                input logic [PTR_W-1:0] idx,
                                                input logic [7:0] b);
        div_cfg_t r;
        r = c;
        case (idx)
            2'd0:    r.m[M_W-1:8] = b[1:0];
            2'd1:    r.m[7:0]     = b;
            default: {r.p, r.na, r.nb} = b[7:1];
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/i2c_line_mon.sv
module i2c_line_mon (
    input  logic clk,
    input  logic rst,
    input  logic scl,
    input  logic sda,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [1:0] line_s;
    logic       scl_p;
    logic       sda_p;

    cfg_sync #(.W(2), .RST_VAL(2'b11)) u_line_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl, sda}),
        .q   (line_s)
    );

    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_cfg_slave.sv
module i2c_cfg_slave
    import synth_cfg_pkg::*;
#(
    parameter logic [3:0] ADDR_HI = 4'b1101
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       addr_strap,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    output logic             sda_oe,
    output logic             commit,
    output logic [PTR_W-1:0] ptr,
    output div_cfg_t         active_cfg
);

    sl_state_t  state;
    role_t      role;
    logic [3:0] bit_cnt;
    logic [7:0] shreg;
    logic [7:0] txsh;
    logic       rw;
    logic       acked;
    logic       dirty;
    div_cfg_t   stage;
    logic [6:0] dev_addr;
    logic [7:0] rd_byte;

    assign dev_addr = {ADDR_HI, addr_strap, 1'b0};

    always_comb rd_byte = cfg_read_byte(stage, ptr);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SL_IDLE;
            role       <= ROLE_ADDR;
            bit_cnt    <= '0;
            shreg      <= '0;
            txsh       <= '0;
            rw         <= 1'b0;
            acked      <= 1'b0;
            dirty      <= 1'b0;
            ptr        <= '0;
            stage      <= '0;
            active_cfg <= '0;
            sda_oe     <= 1'b0;
            commit     <= 1'b0;
        end else begin
            commit <= 1'b0;
            if (stop_det) begin
                state  <= SL_IDLE;
                sda_oe <= 1'b0;
                if (dirty) begin
                    active_cfg <= stage;
                    dirty      <= 1'b0;
                    commit     <= 1'b1;
                end
            end else if (start_det) begin
                state   <= SL_RX;
                role    <= ROLE_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else begin
                case (state)
                    SL_RX: begin
                        if (scl_rise) begin
                            shreg   <= {shreg[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            bit_cnt <= '0;
                            case (role)
                                ROLE_ADDR: begin
                                    if (shreg[7:1] == dev_addr) begin
                                        rw     <= shreg[0];
                                        sda_oe <= 1'b1;
                                        state  <= SL_ACK;
                                    end else begin
                                        state <= SL_IDLE;
                                    end
                                end
                                ROLE_PTR: begin
                                    ptr    <= (shreg < 8'(REG_CNT)) ? shreg[PTR_W-1:0] : '0;
                                    sda_oe <= 1'b1;
                                    state  <= SL_ACK;
                                end
                                default: begin
                                    stage  <= cfg_write_byte(stage, ptr, shreg);
                                    ptr    <= ptr_next(ptr);
                                    dirty  <= 1'b1;
                                    sda_oe <= 1'b1;
                                    state  <= SL_ACK;
                                end
                            endcase
                        end
                    end
                    SL_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (role == ROLE_ADDR && rw) begin
                                txsh   <= rd_byte;
                                sda_oe <= ~rd_byte[7];
                                state  <= SL_TX;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= SL_RX;
                                role   <= (role == ROLE_ADDR) ? ROLE_PTR : ROLE_DATA;
                            end
                        end
                    end
                    SL_TX: begin
                        if (scl_fall) begin
                            if (bit_cnt == 4'd7) begin
                                sda_oe <= 1'b0;
                                state  <= SL_RACK;
                            end else begin
                                txsh    <= {txsh[6:0], 1'b0};
                                sda_oe  <= ~txsh[6];
                                bit_cnt <= bit_cnt + 4'd1;
                            end
                        end
                    end
                    SL_RACK: begin
                        if (scl_rise) begin
                            acked <= ~sda_s;
                            ptr   <= ptr_next(ptr);
                        end else if (scl_fall) begin
                            if (acked) begin
                                txsh    <= rd_byte;
                                sda_oe  <= ~rd_byte[7];
                                bit_cnt <= '0;
                                state   <= SL_TX;
                            end else begin
                                state <= SL_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/synth_cfg_regs.sv
module synth_cfg_regs
    import synth_cfg_pkg::*;
#(
    parameter logic [3:0] ADDR_HI = 4'b1101
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           par_load,
    input  logic [M_W-1:0] par_m,
    input  logic           par_p,
    input  logic [N_W-1:0] par_na,
    input  logic [N_W-1:0] par_nb,
    input  logic [1:0]     addr_strap,
    input  logic           scl,
    input  logic           sda_in,
    output logic           sda_oe,
    output logic [M_W-1:0] m_out,
    output logic           p_out,
    output logic [N_W-1:0] na_out,
    output logic [N_W-1:0] nb_out
);

    logic [CFG_W:0]   par_sync_q;
    logic             sel_s;
    div_cfg_t         par_s;
    div_cfg_t         active_cfg;
    div_cfg_t         out_cfg;
    logic             scl_s;
    logic             sda_s;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic             commit;
    logic [PTR_W-1:0] ptr;

    cfg_sync #(.W(CFG_W + 1), .RST_VAL('0)) u_par_sync (
        .clk (clk),
        .rst (rst),
        .d   ({par_load, par_m, par_p, par_na, par_nb}),
        .q   (par_sync_q)
    );

    assign sel_s = par_sync_q[CFG_W];
    assign par_s = div_cfg_t'(par_sync_q[CFG_W-1:0]);

    i2c_line_mon u_line (
        .clk       (clk),
        .rst       (rst),
        .scl       (scl),
        .sda       (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_cfg_slave #(.ADDR_HI(ADDR_HI)) u_slave (
        .clk        (clk),
        .rst        (rst),
        .addr_strap (addr_strap),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .sda_oe     (sda_oe),
        .commit     (commit),
        .ptr        (ptr),
        .active_cfg (active_cfg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_cfg <= '0;
        end else begin
            out_cfg <= sel_s ? par_s : active_cfg;
        end
    end

    assign m_out  = out_cfg.m;
    assign p_out  = out_cfg.p;
    assign na_out = out_cfg.na;
    assign nb_out = out_cfg.nb;

endmodule

// File: rtl/synth_cfg_regs_chk.sv
module synth_cfg_regs_chk
    import synth_cfg_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             sel_s,
    input div_cfg_t         par_s,
    input div_cfg_t         active_cfg,
    input div_cfg_t         out_cfg,
    input logic             commit,
    input logic             stop_det,
    input logic [PTR_W-1:0] ptr,
    input logic             sda_oe,
    input logic             scl_s
);

    // R1: outputs and SDA drive are clear on the cycle after reset
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (out_cfg == '0 && !sda_oe && ptr == '0));

    // R2: with parallel selected, outputs carry the synchronized pins
    assert_par_follow_R2: assert property (@(posedge clk) disable iff (rst)
        $past(sel_s) |-> (out_cfg == $past(par_s)));

    // R3: with serial selected, outputs carry the committed registers
    assert_serial_source_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(sel_s) |-> (out_cfg == $past(active_cfg)));

    // R8: outputs hold unless a commit happened or the source was parallel
    assert_hold_no_commit_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(sel_s) && !$past(sel_s, 2) && !$past(commit)) |-> $stable(out_cfg));

    // R8: a commit only follows a STOP
    assert_commit_on_stop_R8: assert property (@(posedge clk) disable iff (rst)
        commit |-> $past(stop_det));

    // R7: pointer never leaves the three-register range
    assert_ptr_range_R7: assert property (@(posedge clk) disable iff (rst)
        ptr != 2'd3);

    // R10: SDA drive changes only while SCL is low
    assert_oe_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !scl_s);

endmodule

bind synth_cfg_regs synth_cfg_regs_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .sel_s      (sel_s),
    .par_s      (par_s),
    .active_cfg (active_cfg),
    .out_cfg    (out_cfg),
    .commit     (commit),
    .stop_det   (stop_det),
    .ptr        (ptr),
    .sda_oe     (sda_oe),
    .scl_s      (scl_s)
);

// File: tb/synth_cfg_regs_bench.sv
`timescale 1ns/1ps
module synth_cfg_regs_bench;

    localparam int H       = 6;
    localparam int WD_CYC  = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       par_load = 1'b0;
    logic [9:0] par_m = '0;
    logic       par_p = 1'b0;
    logic [2:0] par_na = '0;
    logic [2:0] par_nb = '0;
    logic [1:0] addr_strap = 2'b01;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic [9:0] m_out;
    logic       p_out;
    logic [2:0] na_out;
    logic [2:0] nb_out;
    wire        sda_bus = sda_m & ~sda_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    synth_cfg_regs u_synth_cfg_regs (
        .clk        (clk),
        .rst        (rst),
        .par_load   (par_load),
        .par_m      (par_m),
        .par_p      (par_p),
        .par_na     (par_na),
        .par_nb     (par_nb),
        .addr_strap (addr_strap),
        .scl        (scl),
        .sda_in     (sda_bus),
        .sda_oe     (sda_oe),
        .m_out      (m_out),
        .p_out      (p_out),
        .na_out     (na_out),
        .nb_out     (nb_out)
    );

    function automatic logic [31:0] ex(input logic [9:0] m, input logic p,
                                       input logic [2:0] na, input logic [2:0] nb);
        return {15'b0, m, p, na, nb};
    endfunction

    function automatic logic [31:0] outs();
        return {15'b0, m_out, p_out, na_out, nb_out};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; tick(H);
        scl = 1'b1;   tick(H);
        sda_m = 1'b0; tick(H);
        scl = 1'b0;   tick(H);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; tick(H);
        scl = 1'b1;   tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic i2c_wr(input logic [7:0] d, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = d[i]; tick(H);
            scl = 1'b1;   tick(H);
            scl = 1'b0;   tick(H);
        end
        sda_m = 1'b1; tick(H);
        scl = 1'b1;   tick(H / 2);
        ack = ~sda_bus;
        tick(H - H / 2);
        scl = 1'b0;   tick(H);
    endtask

    task automatic i2c_rd(input logic nack, output logic [7:0] d);
        d = '0;
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(H);
            scl = 1'b1; tick(H / 2);
            d = {d[6:0], sda_bus};
            tick(H - H / 2);
            scl = 1'b0;
        end
        sda_m = nack; tick(H);
        scl = 1'b1;   tick(H);
        scl = 1'b0;   tick(H);
        sda_m = 1'b1;
    endtask

    task automatic do_reset();
        rst = 1'b1; tick(3);
        rst = 1'b0; tick(1);
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1", "outputs after reset", outs(), 32'h0);
        chk("R1", "sda_oe after reset", {31'b0, sda_oe}, 32'h0);
    endtask

    task automatic t_parallel_timing();
        par_load = 1'b1; tick(4);
        par_m = 10'h2F1; par_p = 1'b1; par_na = 3'd6; par_nb = 3'd2;
        tick(2);
        chk("R2", "not yet after two edges", outs(), 32'h0);
        tick(1);
        chk("R2", "due on third edge", outs(), ex(10'h2F1, 1'b1, 3'd6, 3'd2));
        par_m = 10'h00A; par_p = 1'b0; par_na = 3'd1; par_nb = 3'd7;
        tick(2);
        chk("R2", "second pattern held", outs(), ex(10'h2F1, 1'b1, 3'd6, 3'd2));
        tick(1);
        chk("R2", "second pattern due", outs(), ex(10'h00A, 1'b0, 3'd1, 3'd7));
        par_load = 1'b0; tick(4);
        chk("R3", "serial source after reset is zero", outs(), 32'h0);
    endtask

    task automatic t_write_commit();
        logic a;
        i2c_start();
        i2c_wr(8'hD4, a); chk("R5", "addr ack", {31'b0, a}, 32'h1);
        i2c_wr(8'h00, a); chk("R5", "ptr ack", {31'b0, a}, 32'h1);
        i2c_wr(8'hFE, a); chk("R6", "byte0 ack", {31'b0, a}, 32'h1);
        i2c_wr(8'hA5, a); chk("R7", "byte1 ack", {31'b0, a}, 32'h1);
        i2c_wr(8'hD6, a); chk("R7", "byte2 ack", {31'b0, a}, 32'h1);
        tick(8);
        chk("R8", "no change before stop", outs(), 32'h0);
        i2c_stop(); tick(8);
        chk("R6", "committed layout", outs(), ex(10'h2A5, 1'b1, 3'd5, 3'd3));
    endtask

    task automatic t_wrong_addr();
        logic a;
        i2c_start();
        i2c_wr(8'hC4, a); chk("R4", "foreign addr nack", {31'b0, a}, 32'h0);
        i2c_wr(8'h01, a);
        i2c_wr(8'h11, a);
        i2c_stop(); tick(8);
        chk("R4", "foreign write ignored", outs(), ex(10'h2A5, 1'b1, 3'd5, 3'd3));
    endtask

    task automatic t_strap();
        logic a;
        addr_strap = 2'b10; tick(2);
        i2c_start();
        i2c_wr(8'hD4, a); chk("R4", "old strap addr nack", {31'b0, a}, 32'h0);
        i2c_stop();
        i2c_start();
        i2c_wr(8'hD8, a); chk("R4", "new strap addr ack", {31'b0, a}, 32'h1);
        i2c_wr(8'h01, a);
        i2c_wr(8'h3C, a);
        i2c_stop(); tick(8);
        chk("R4", "write via new strap", outs(), ex(10'h23C, 1'b1, 3'd5, 3'd3));
        addr_strap = 2'b01; tick(2);
    endtask

    task automatic t_readback();
        logic a;
        logic [7:0] d;
        i2c_start();
        i2c_wr(8'hD4, a);
        i2c_wr(8'h01, a);
        i2c_start();
        i2c_wr(8'hD5, a); chk("R9", "read addr ack", {31'b0, a}, 32'h1);
        i2c_rd(1'b0, d);  chk("R9", "read byte1", {24'b0, d}, 32'h3C);
        i2c_rd(1'b0, d);  chk("R6", "read byte2", {24'b0, d}, 32'hD6);
        i2c_rd(1'b1, d);  chk("R7", "read wraps to byte0", {24'b0, d}, 32'h02);
        i2c_stop(); tick(8);
        chk("R8", "read-only transfer no change", outs(), ex(10'h23C, 1'b1, 3'd5, 3'd3));
    endtask

    task automatic t_ptr_clamp();
        logic a;
        i2c_start();
        i2c_wr(8'hD4, a);
        i2c_wr(8'h07, a); chk("R7", "large ptr ack", {31'b0, a}, 32'h1);
        i2c_wr(8'h03, a);
        i2c_stop(); tick(8);
        chk("R7", "large ptr lands on byte0", outs(), ex(10'h33C, 1'b1, 3'd5, 3'd3));
    endtask

    task automatic t_override();
        logic a;
        par_m = 10'h155; par_p = 1'b0; par_na = 3'd2; par_nb = 3'd6;
        par_load = 1'b1; tick(4);
        chk("R3", "parallel overrides", outs(), ex(10'h155, 1'b0, 3'd2, 3'd6));
        i2c_start();
        i2c_wr(8'hD4, a);
        i2c_wr(8'h02, a);
        i2c_wr(8'h28, a);
        i2c_stop(); tick(8);
        chk("R3", "serial write masked", outs(), ex(10'h155, 1'b0, 3'd2, 3'd6));
        par_load = 1'b0; tick(4);
        chk("R3", "serial values return", outs(), ex(10'h33C, 1'b0, 3'd2, 3'd4));
    endtask

    task automatic t_reset_again();
        logic a;
        logic [7:0] d;
        do_reset();
        chk("R1", "outputs cleared by reset", outs(), 32'h0);
        i2c_start();
        i2c_wr(8'hD5, a);
        i2c_rd(1'b1, d);
        i2c_stop(); tick(4);
        chk("R1", "registers cleared by reset", {24'b0, d}, 32'h00);
    endtask

    initial begin
        tick(WD_CYC);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_parallel_timing();
        t_write_commit();
        t_wrong_addr();
        t_strap();
        t_readback();
        t_ptr_clamp();
        t_override();
        t_reset_again();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule